// File: doc/BRIEF.md
# Invalidate Queue with Early Acknowledge

This block sits between the coherence interconnect and one cache. When an incoming invalidate request is accepted, it returns the acknowledgement straight away. The line address goes into a small ordered queue. The queued invalidations are then passed to the cache one at a time, whenever the cache's invalidate port can take one. The acknowledgement therefore no longer waits on a busy cache, and the requester can move on sooner.

Acknowledging early is a promise: no outgoing coherence message may concern a line whose invalidation is still queued. To keep that promise, the outgoing message path presents a line address to a lookup port. The block raises a hold signal while any stored entry carries that address.

The block also serves barriers. A read barrier completes only while the queue is empty. A full barrier completes only while the queue is empty and the store buffer reports that it is empty too.

Top module: `inval_queue`

## Requirements
- R1: After reset the queue is empty. `inv_ready` is 1, and `ack_valid`, `cache_inv_valid` and `query_block` are 0.
- R2: An invalidate is accepted on a rising edge where `inv_valid` and `inv_ready` are both 1. Each accepted invalidate raises `ack_valid` for the following cycle only, with `ack_line` equal to the accepted line. This happens whatever the state of `cache_inv_ready`.
- R3: Stored entries are offered on `cache_inv_line` in the order they were accepted. The head entry leaves on an edge where `cache_inv_valid` and `cache_inv_ready` are both 1, and at most one entry leaves per cycle. While `cache_inv_ready` is 0, the head line stays unchanged.
- R4: Holding DEPTH entries, the queue drives `inv_ready` to 0. No invalidate is accepted and no acknowledge follows. `inv_ready` returns to 1 in the cycle after an entry leaves.
- R5: `query_block` is 1 in the same cycle whenever `query_line` equals the line of an entry held in the queue. An entry is held once it has been accepted on an earlier edge and until the edge on which it leaves.
- R6: `rbar_done` is 1 exactly when `rbar_req` is 1 and the queue holds no entry.
- R7: `mb_done` is 1 exactly when `mb_req` is 1, the queue holds no entry and `sb_empty` is 1.
- R8: Two or more entries with the same line are kept as separate entries. `query_block` for that line stays 1 until the last of them has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidate request present |
| inv_line | input | ADDR_W | Line address of the incoming invalidate |
| inv_ready | output | 1 | Queue can accept an invalidate this cycle |
| ack_valid | output | 1 | Acknowledge for the invalidate accepted last cycle |
| ack_line | output | ADDR_W | Line address being acknowledged |
| cache_inv_valid | output | 1 | A queued invalidation is offered to the cache |
| cache_inv_line | output | ADDR_W | Line to invalidate in the cache |
| cache_inv_ready | input | 1 | Cache takes the offered invalidation this cycle |
| query_line | input | ADDR_W | Line address of a pending outgoing message |
| query_block | output | 1 | Hold the outgoing message: line has a queued invalidation |
| rbar_req | input | 1 | Read barrier waiting |
| rbar_done | output | 1 | Read barrier may complete |
| mb_req | input | 1 | Full barrier waiting |
| sb_empty | input | 1 | Store buffer holds no pending store |
| mb_done | output | 1 | Full barrier may complete |

## Verification
The assertions rely on the requester holding `inv_line` stable only in the accepting cycle; nothing is assumed across cycles. They also rely on `cache_inv_ready` being meaningful only while `cache_inv_valid` is 1. The bench changes every input only at the falling edge. It takes line addresses from a set of eight values, so duplicate entries and lookup hits are frequent. It runs phases that hold the cache port stalled until the queue fills and then drain it to empty, so that back-pressure and both barrier outcomes are reached.

// File: rtl/ivq_pkg.sv
package ivq_pkg;

  // Next slot index on a ring of the given depth.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of push and pop.
  function automatic int unsigned occ_after(input int unsigned occ, input logic push, input logic pop);
    int unsigned r;
    r = occ;
    if (push) r = r + 1;
    if (pop)  r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/ivq_store.sv
module ivq_store #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_line,
  input  logic                          pop,
  output logic [ADDR_W-1:0]             head_line,
  output logic [DEPTH-1:0]              slot_vld,
  output logic [DEPTH-1:0][ADDR_W-1:0]  slot_line,
  output logic                          empty,
  output logic                          full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;

  assign empty     = (occ == '0);
  assign full      = (occ == CNT_W'(DEPTH));
  assign head_line = slot_line[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ       <= '0;
      slot_vld  <= '0;
      slot_line <= '0;
    end else begin
      if (pop) begin
        slot_vld[rd_ptr] <= 1'b0;
        rd_ptr <= PTR_W'(ivq_pkg::ring_next(int'(rd_ptr), DEPTH));
      end
      if (push) begin
        slot_vld[wr_ptr]  <= 1'b1;
        slot_line[wr_ptr] <= push_line;
        wr_ptr <= PTR_W'(ivq_pkg::ring_next(int'(wr_ptr), DEPTH));
      end
      occ <= CNT_W'(ivq_pkg::occ_after(int'(occ), push, pop));
    end
  end

  // R4: a push never lands on a full ring; flag count agrees with occupancy.
  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_no_overflow_R4: assert (!(push && full));
      assert_flag_count_R3: assert ($countones(slot_vld) == int'(occ));
    end
  end

endmodule

// File: rtl/ivq_match.sv
module ivq_match #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic [DEPTH-1:0]              slot_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_line,
  input  logic [ADDR_W-1:0]             query_line,
  output logic                          hit
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = slot_vld[g] && (slot_line[g] == query_line);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/ivq_ack.sv
module ivq_ack #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] accept_line,
  output logic              ack_valid,
  output logic [ADDR_W-1:0] ack_line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_line  <= '0;
    end else begin
      ack_valid <= accept;
      if (accept) ack_line <= accept_line;
    end
  end
endmodule

// File: rtl/ivq_barrier.sv
module ivq_barrier (
  input  logic rbar_req,
  input  logic mb_req,
  input  logic queue_empty,
  input  logic sb_empty,
  output logic rbar_done,
  output logic mb_done
);
  assign rbar_done = rbar_req && queue_empty;
  assign mb_done   = mb_req && queue_empty && sb_empty;
endmodule

// File: rtl/inval_queue.sv
module inval_queue #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_line,
  output logic              inv_ready,
  output logic              ack_valid,
  output logic [ADDR_W-1:0] ack_line,
  output logic              cache_inv_valid,
  output logic [ADDR_W-1:0] cache_inv_line,
  input  logic              cache_inv_ready,
  input  logic [ADDR_W-1:0] query_line,
  output logic              query_block,
  input  logic              rbar_req,
  output logic              rbar_done,
  input  logic              mb_req,
  input  logic              sb_empty,
  output logic              mb_done
);
  logic                         q_empty, q_full;
  logic                         accept_evt, retire_evt;
  logic [DEPTH-1:0]             slot_vld;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_line;

  assign inv_ready       = !q_full;
  assign accept_evt      = inv_valid && inv_ready;
  assign cache_inv_valid = !q_empty;
  assign retire_evt      = cache_inv_valid && cache_inv_ready;

  ivq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(accept_evt), .push_line(inv_line), .pop(retire_evt),
    .head_line(cache_inv_line), .slot_vld(slot_vld), .slot_line(slot_line),
    .empty(q_empty), .full(q_full)
  );

  ivq_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
    .slot_vld(slot_vld), .slot_line(slot_line),
    .query_line(query_line), .hit(query_block)
  );

  ivq_ack #(.ADDR_W(ADDR_W)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .accept(accept_evt), .accept_line(inv_line),
    .ack_valid(ack_valid), .ack_line(ack_line)
  );

  ivq_barrier u_barrier (
    .rbar_req(rbar_req), .mb_req(mb_req),
    .queue_empty(q_empty), .sb_empty(sb_empty),
    .rbar_done(rbar_done), .mb_done(mb_done)
  );

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> ack_valid && ack_line == $past(inv_line));

  assert_no_ack_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_ready |=> !ack_valid);

  assert_head_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_inv_valid && !cache_inv_ready |=> cache_inv_valid && $stable(cache_inv_line));

  assert_head_embargo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_inv_valid && query_line == cache_inv_line |-> query_block);

  assert_rbar_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rbar_done |-> !cache_inv_valid && !query_block);

  assert_mb_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mb_done |-> sb_empty && !cache_inv_valid);

endmodule

// File: tb/inval_queue_bench.sv
module inval_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_valid = 1'b0, cache_inv_ready = 1'b0;
  logic rbar_req = 1'b0, mb_req = 1'b0, sb_empty = 1'b0;
  logic [ADDR_W-1:0] inv_line = '0, query_line = '0;
  logic inv_ready, ack_valid, cache_inv_valid, query_block, rbar_done, mb_done;
  logic [ADDR_W-1:0] ack_line, cache_inv_line;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [ADDR_W-1:0] model_q[$];
  logic              exp_ack = 1'b0;
  logic [ADDR_W-1:0] exp_ack_line = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inval_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_inval_queue (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_line(inv_line), .inv_ready(inv_ready),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .cache_inv_valid(cache_inv_valid), .cache_inv_line(cache_inv_line),
    .cache_inv_ready(cache_inv_ready),
    .query_line(query_line), .query_block(query_block),
    .rbar_req(rbar_req), .rbar_done(rbar_done),
    .mb_req(mb_req), .sb_empty(sb_empty), .mb_done(mb_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int hits(input logic [ADDR_W-1:0] line);
    int n = 0;
    foreach (model_q[i]) if (model_q[i] == line) n++;
    return n;
  endfunction

  task automatic compare_all();
    bit e_ready, e_cv, e_blk, e_rb, e_mb;
    int nh;
    e_ready = model_q.size() < DEPTH;
    e_cv    = model_q.size() > 0;
    nh      = hits(query_line);
    e_blk   = nh > 0;
    e_rb    = rbar_req && model_q.size() == 0;
    e_mb    = mb_req && model_q.size() == 0 && sb_empty;
    check(inv_ready == e_ready, "R4", "inv_ready", int'(inv_ready), int'(e_ready));
    check(ack_valid == exp_ack, "R2", "ack_valid", int'(ack_valid), int'(exp_ack));
    if (exp_ack)
      check(ack_line == exp_ack_line, "R2", "ack_line", int'(ack_line), int'(exp_ack_line));
    check(cache_inv_valid == e_cv, "R3", "cache_inv_valid", int'(cache_inv_valid), int'(e_cv));
    if (e_cv)
      check(cache_inv_line == model_q[0], "R3", "cache_inv_line", int'(cache_inv_line), int'(model_q[0]));
    if (nh > 1)
      check(query_block == e_blk, "R8", "query_block dup", int'(query_block), int'(e_blk));
    else
      check(query_block == e_blk, "R5", "query_block", int'(query_block), int'(e_blk));
    check(rbar_done == e_rb, "R6", "rbar_done", int'(rbar_done), int'(e_rb));
    check(mb_done == e_mb, "R7", "mb_done", int'(mb_done), int'(e_mb));
  endtask

  task automatic run_cycles(input int n, input int p_inv, input int p_rdy);
    for (int c = 0; c < n; c++) begin
      bit acc, pop;
      @(negedge clk);
      inv_valid       = ($urandom_range(99) < p_inv);
      inv_line        = ADDR_W'($urandom_range(7));
      cache_inv_ready = ($urandom_range(99) < p_rdy);
      if (model_q.size() > 0 && $urandom_range(3) == 0)
        query_line = model_q[$urandom_range(model_q.size() - 1)];
      else
        query_line = ADDR_W'($urandom_range(9));
      rbar_req = $urandom_range(1);
      mb_req   = $urandom_range(1);
      sb_empty = $urandom_range(1);
      #1;
      compare_all();
      @(posedge clk);
      acc = inv_valid && (model_q.size() < DEPTH);
      pop = (model_q.size() > 0) && cache_inv_ready;
      if (pop) void'(model_q.pop_front());
      if (acc) model_q.push_back(inv_line);
      exp_ack = acc;
      if (acc) exp_ack_line = inv_line;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(inv_ready == 1'b1, "R1", "inv_ready after reset", int'(inv_ready), 1);
    check(ack_valid == 1'b0, "R1", "ack_valid after reset", int'(ack_valid), 0);
    check(cache_inv_valid == 1'b0, "R1", "cache_inv_valid after reset", int'(cache_inv_valid), 0);
    check(query_block == 1'b0, "R1", "query_block after reset", int'(query_block), 0);
    // Fill with cache stalled (R4, R2, R8), then drain (R3, R6, R7).
    for (int k = 0; k < 6; k++) begin
      run_cycles(20, 90, 0);
      run_cycles(20, 0, 80);
    end
    run_cycles(1500, 50, 50);
    run_cycles(500, 80, 20);
    run_cycles(500, 20, 80);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule